// File: doc/BRIEF.md
# Raster Timing Generator

This block turns a pixel clock into display raster timing. A pixel counter runs across each line, and a second counter advances every half line, so that one frame holds a programmable number of half-lines. A progressive frame of V lines is set up with 2·V half-lines. The first half of the frame counts as the top field and the second half as the bottom field. Each field selects its own active-video window and its own set of vertical sync settings.

Four sync channels are driven at once. Each channel has a horizontal pulse and a vertical pulse for each field. A vertical pulse starts and stops at a chosen pixel inside a chosen line. Software programs the block through a simple write port. All settings go into shadow registers and reach the counters only at a frame start, so a running frame is never torn. The block runs free in master mode. In slave mode a rising edge on an external sync input restarts it. A write-only command also restarts it. Every output is registered, so an output reflects the counter position one clock earlier.

Top module: `raster_timing_gen`

## Requirements
- R1: The line-length setting (address 1, bits 15:0) gives L pixel clocks per line. The pixel counter runs from 0 to L-1, and a frame repeats every L·F/2 clocks, with F the field-length setting.
- R2: The field-length setting (address 2, bits 15:0) gives F half-lines per frame. The line number is (half-line count / 2) + 1. Half-lines F/2 and above form the bottom field, and bot_evt comes L·F/4 clocks after top_evt.
- R3: The window settings sit at address 4 (top start), 5 (top stop), 6 (bottom start) and 7 (bottom stop), each holding the line in bits 31:16 and the pixel in bits 15:0. active is high when both the line and the pixel lie within the inclusive bounds of the current field's pair.
- R4: For channel c, address 8+8c holds the horizontal end pixel in bits 31:16 and the start pixel in bits 15:0. hsync[c] is high while start <= pixel < end.
- R5: For channel c, addresses 9+8c and 10+8c hold the top-field and bottom-field line bounds. Addresses 11+8c and 12+8c hold the top-field and bottom-field pixel bounds. In each, the end sits in bits 31:16 and the start in bits 15:0. vsync[c] is high from the point (start line, start pixel) up to, but not including, (end line, end pixel) of the current field.
- R6: A channel whose start equals its end keeps that output low.
- R7: top_evt is a single-cycle pulse for pixel 0 of half-line 0. bot_evt is a single-cycle pulse for pixel 0 of half-line F/2. The two pulses never coincide.
- R8: Bit 0 of address 0 selects the mode: 0 is master, which ignores ext_sync, and 1 is slave. In slave mode a rising edge of ext_sync restarts both counters, and holding the input high does not restart them again.
- R9: Writing a value with bit 0 set to address 3 restarts both counters, and top_evt shows on the second clock after the write. Writing 0 there has no effect.
- R10: Writes to the mode, length, window and channel settings take effect only at the next frame start, which is either a natural wrap or a restart.
- R11: While reset is asserted, every output is low. After reset, L is 16, F is 8, the mode is master, and all window and channel settings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (6) | Register write address |
| wr_data | input | 32 | Register write data |
| ext_sync | input | 1 | External sync for slave mode, synchronous to clk |
| hsync | output | NCH (4) | Horizontal sync, one bit per channel |
| vsync | output | NCH (4) | Vertical sync, one bit per channel |
| active | output | 1 | Active-video flag |
| top_evt | output | 1 | Top-field start pulse |
| bot_evt | output | 1 | Bottom-field start pulse |

## Verification
The assertions assume the line length is at least 2 and the field length is even and at least 2. The counter range checks and the separation of the two field events rely on this. They also assume ext_sync is already synchronous to the pixel clock. The stimulus only ever programs lengths of 20 or 40 pixels with 12 or 4 half-lines, and it drives ext_sync and every write on the falling edge, so every input is stable at the sampling edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned HW = 16;
  typedef logic [HW-1:0] half_t;

  // hi: end / line half, lo: start / pixel half
  typedef struct packed {
    half_t hi;
    half_t lo;
  } span_t;

  typedef struct packed {
    span_t hor;
    span_t vl_top;
    span_t vl_bot;
    span_t vp_top;
    span_t vp_bot;
  } chan_cfg_t;

  typedef struct packed {
    span_t top_start;
    span_t top_stop;
    span_t bot_start;
    span_t bot_stop;
  } win_cfg_t;

  localparam int unsigned RA_MODE   = 0;
  localparam int unsigned RA_LINE   = 1;
  localparam int unsigned RA_FIELD  = 2;
  localparam int unsigned RA_RST    = 3;
  localparam int unsigned RA_WIN    = 4;
  localparam int unsigned RA_CH     = 8;
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned CH_SPANS  = 5;
  localparam int unsigned WIN_SPANS = 4;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 6,
  parameter int DEF_LINE  = 16,
  parameter int DEF_FIELD = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            frame_start,
  output logic            soft_rst,
  output logic            slave,
  output half_t           line_len,
  output half_t           field_len,
  output win_cfg_t        win,
  output chan_cfg_t       chan [NCH]
);
  localparam int unsigned NSPAN    = WIN_SPANS + NCH * CH_SPANS;
  localparam int unsigned IW       = $clog2(NSPAN);
  localparam int unsigned TOP_ADDR = RA_CH + NCH * CH_STRIDE;

  span_t          sh_span [NSPAN];
  span_t          ac_span [NSPAN];
  half_t          sh_line, sh_field, ac_line, ac_field;
  logic           sh_slave, ac_slave;
  logic           span_hit;
  logic [IW-1:0]  span_idx;
  int unsigned    a_u, off_u;

  // address decode into the flat span store
  always_comb begin
    a_u      = {{(32-AW){1'b0}}, wr_addr};
    off_u    = a_u - RA_CH;
    span_hit = 1'b0;
    span_idx = '0;
    if (a_u >= RA_WIN && a_u < RA_CH) begin
      span_hit = 1'b1;
      span_idx = IW'(a_u - RA_WIN);
    end else if (a_u >= RA_CH && a_u < TOP_ADDR && (off_u % CH_STRIDE) < CH_SPANS) begin
      span_hit = 1'b1;
      span_idx = IW'(WIN_SPANS + (off_u / CH_STRIDE) * CH_SPANS + (off_u % CH_STRIDE));
    end
  end

  assign soft_rst = wr_en && (a_u == RA_RST) && wr_data[0];

  // shadow copy: written by software at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NSPAN); i++) sh_span[i] <= '0;
      sh_line  <= half_t'(DEF_LINE);
      sh_field <= half_t'(DEF_FIELD);
      sh_slave <= 1'b0;
    end else if (wr_en) begin
      if (span_hit)          sh_span[span_idx] <= wr_data;
      if (a_u == RA_LINE)    sh_line  <= wr_data[HW-1:0];
      if (a_u == RA_FIELD)   sh_field <= wr_data[HW-1:0];
      if (a_u == RA_MODE)    sh_slave <= wr_data[0];
    end
  end

  // working copy: refreshed only at a frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NSPAN); i++) ac_span[i] <= '0;
      ac_line  <= half_t'(DEF_LINE);
      ac_field <= half_t'(DEF_FIELD);
      ac_slave <= 1'b0;
    end else if (frame_start) begin
      for (int i = 0; i < int'(NSPAN); i++) ac_span[i] <= sh_span[i];
      ac_line  <= sh_line;
      ac_field <= sh_field;
      ac_slave <= sh_slave;
    end
  end

  assign slave         = ac_slave;
  assign line_len      = ac_line;
  assign field_len     = ac_field;
  assign win.top_start = ac_span[0];
  assign win.top_stop  = ac_span[1];
  assign win.bot_start = ac_span[2];
  assign win.bot_stop  = ac_span[3];

  for (genvar c = 0; c < NCH; c++) begin : g_chan_map
    localparam int unsigned B = WIN_SPANS + c * CH_SPANS;
    assign chan[c].hor    = ac_span[B + 0];
    assign chan[c].vl_top = ac_span[B + 1];
    assign chan[c].vl_bot = ac_span[B + 2];
    assign chan[c].vp_top = ac_span[B + 3];
    assign chan[c].vp_bot = ac_span[B + 4];
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  half_t line_len,
  input  half_t field_len,
  output half_t hcnt,
  output half_t vcnt,
  output logic  frame_start
);
  half_t mid_h;
  logic  eol, step, eof;

  assign mid_h       = line_len >> 1;
  assign eol         = (hcnt == line_len - half_t'(1));
  assign step        = eol || (hcnt == mid_h - half_t'(1));
  assign eof         = (vcnt == field_len - half_t'(1));
  assign frame_start = restart || (eol && eof);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= eol ? '0 : hcnt + half_t'(1);
      if (step) vcnt <= eof ? '0 : vcnt + half_t'(1);
    end
  end
endmodule

// File: rtl/rtg_sync_chan.sv
module rtg_sync_chan
  import rtg_pkg::*;
(
  input  half_t     hcnt,
  input  half_t     line,
  input  logic      bottom,
  input  chan_cfg_t cfg,
  output logic      hs,
  output logic      vs
);
  span_t vl, vp;
  logic  past_start, before_end;

  assign vl = bottom ? cfg.vl_bot : cfg.vl_top;
  assign vp = bottom ? cfg.vp_bot : cfg.vp_top;

  assign hs = (hcnt >= cfg.hor.lo) && (hcnt < cfg.hor.hi);

  // (line, pixel) ordered lexicographically against start and end points
  assign past_start = (line > vl.lo) || ((line == vl.lo) && (hcnt >= vp.lo));
  assign before_end = (line < vl.hi) || ((line == vl.hi) && (hcnt < vp.hi));
  assign vs         = past_start && before_end;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 6,
  parameter int DEF_LINE  = 16,
  parameter int DEF_FIELD = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           ext_sync,
  output logic [NCH-1:0] hsync,
  output logic [NCH-1:0] vsync,
  output logic           active,
  output logic           top_evt,
  output logic           bot_evt
);
  logic           soft_rst, slave, frame_start, restart, ext_q;
  half_t          line_len, field_len, hcnt, vcnt, half_field, line;
  win_cfg_t       win;
  chan_cfg_t      chan [NCH];
  logic           bottom, act_c;
  logic [NCH-1:0] hs_c, vs_c;
  span_t          ws, we;

  rtg_regs #(
    .NCH(NCH), .AW(AW), .DEF_LINE(DEF_LINE), .DEF_FIELD(DEF_FIELD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .soft_rst(soft_rst), .slave(slave),
    .line_len(line_len), .field_len(field_len), .win(win), .chan(chan)
  );

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_sync;
  end

  assign restart = soft_rst || (slave && ext_sync && !ext_q);

  rtg_counters u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .line_len(line_len),
    .field_len(field_len), .hcnt(hcnt), .vcnt(vcnt), .frame_start(frame_start)
  );

  assign half_field = field_len >> 1;
  assign bottom     = (vcnt >= half_field);
  assign line       = (vcnt >> 1) + half_t'(1);

  assign ws    = bottom ? win.bot_start : win.top_start;
  assign we    = bottom ? win.bot_stop  : win.top_stop;
  assign act_c = (line >= ws.hi) && (line <= we.hi) && (hcnt >= ws.lo) && (hcnt <= we.lo);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rtg_sync_chan u_chan (
      .hcnt(hcnt), .line(line), .bottom(bottom), .cfg(chan[c]),
      .hs(hs_c[c]), .vs(vs_c[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync   <= '0;
      vsync   <= '0;
      active  <= 1'b0;
      top_evt <= 1'b0;
      bot_evt <= 1'b0;
    end else begin
      hsync   <= hs_c;
      vsync   <= vs_c;
      active  <= act_c;
      top_evt <= (hcnt == '0) && (vcnt == '0);
      bot_evt <= (hcnt == '0) && (vcnt == half_field);
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           top_evt,
  input logic           bot_evt,
  input logic           active,
  input logic           restart,
  input logic [NCH-1:0] hsync,
  input logic [NCH-1:0] vsync,
  input half_t          hcnt,
  input half_t          vcnt,
  input half_t          line_len,
  input half_t          field_len
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_quiet_R11: assert (hsync == '0 && vsync == '0 && !active && !top_evt && !bot_evt)
        else $error("outputs not low after reset edge");
    end
  end

  assert_hcnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    hcnt < line_len);

  assert_vcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    vcnt < field_len);

  assert_top_origin_R7: assert property (@(posedge clk) disable iff (rst)
    top_evt |-> ($past(hcnt) == '0 && $past(vcnt) == '0));

  assert_top_single_R7: assert property (@(posedge clk) disable iff (rst)
    top_evt |=> !top_evt);

  assert_evt_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(top_evt && bot_evt));

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (hcnt == '0 && vcnt == '0));
endmodule

bind raster_timing_gen rtg_checker #(.NCH(NCH)) u_rtg_chk (
  .clk(clk), .rst(rst), .top_evt(top_evt), .bot_evt(bot_evt), .active(active),
  .restart(restart), .hsync(hsync), .vsync(vsync), .hcnt(hcnt), .vcnt(vcnt),
  .line_len(line_len), .field_len(field_len)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_sync = 1'b0;
  logic [3:0]  hsync, vsync;
  logic        active, top_evt, bot_evt;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_sync(ext_sync), .hsync(hsync), .vsync(vsync), .active(active),
    .top_evt(top_evt), .bot_evt(bot_evt)
  );

  // {position n, hsync[3:0], vsync[3:0], active, top_evt, bot_evt}
  // config: L=20, F=12 (6 lines, bottom field = lines 4..6)
  localparam logic [26:0] VEC [18] = '{
    {16'd0,   11'b0000_0001_010},
    {16'd1,   11'b0000_0001_000},
    {16'd3,   11'b0001_0001_000},
    {16'd10,  11'b0010_0001_000},
    {16'd19,  11'b1000_0001_000},
    {16'd20,  11'b0000_0000_000},
    {16'd25,  11'b0001_0010_100},
    {16'd28,  11'b0000_0000_100},
    {16'd44,  11'b0001_0000_100},
    {16'd55,  11'b0000_1000_100},
    {16'd56,  11'b0000_1000_000},
    {16'd60,  11'b0000_0000_001},
    {16'd70,  11'b0010_0001_000},
    {16'd82,  11'b0001_0001_100},
    {16'd83,  11'b0001_0000_100},
    {16'd109, 11'b0000_0000_100},
    {16'd110, 11'b0010_0000_000},
    {16'd120, 11'b0000_0001_010}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_top();
    do @(negedge clk); while (!top_evt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int c;
    bit early;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset outputs", {21'd0, hsync, vsync, active, top_evt, bot_evt}, 32'd0);
    rst = 1'b0;

    // configuration (shadowed until the restart below)
    wr(1, 32'd20);
    wr(2, 32'd12);
    wr(4, {16'd2, 16'd4});
    wr(5, {16'd3, 16'd15});
    wr(6, {16'd5, 16'd2});
    wr(7, {16'd6, 16'd9});
    wr(8,  {16'd6, 16'd2});
    wr(9,  {16'd2, 16'd1});
    wr(10, {16'd5, 16'd4});
    wr(11, {16'd0, 16'd0});
    wr(12, {16'd3, 16'd10});
    wr(16, {16'd11, 16'd10});
    wr(17, {16'd2, 16'd2});
    wr(19, {16'd8, 16'd5});
    wr(24, {16'd5, 16'd5});
    wr(25, {16'd3, 16'd3});
    wr(27, {16'd7, 16'd7});
    wr(32, {16'd20, 16'd18});
    wr(33, {16'd4, 16'd3});
    wr(35, {16'd0, 16'd15});
    wr(3, 32'd1);

    // table walk: n visible at the (n+1)-th falling edge after the write
    k = 0;
    for (int i = 0; i < 18; i++) begin
      int n;
      logic [10:0] e;
      n = int'(VEC[i][26:11]);
      e = VEC[i][10:0];
      while (k < n + 1) begin @(negedge clk); k++; end
      chk("R1 R3 R4 R5 R6 R7", $sformatf("table n=%0d", n),
          {21'd0, hsync, vsync, active, top_evt, bot_evt}, {21'd0, e});
    end

    // R2: bottom event L*F/4 clocks after top event
    c = 0;
    do begin @(negedge clk); c++; end while (!bot_evt);
    chk("R2", "top to bottom event", 32'(c), 32'd60);

    // R10: mid-frame writes wait for the frame start
    wait_top();
    wr(1, 32'd40);
    wr(2, 32'd4);
    c = 4;
    do begin @(negedge clk); c++; end while (!top_evt);
    chk("R10", "old frame length kept", 32'(c), 32'd120);
    c = 0;
    do begin @(negedge clk); c++; end while (!top_evt);
    chk("R10 R1", "new frame length", 32'(c), 32'd80);

    // R9: restart command and a write of zero
    repeat (30) @(negedge clk);
    wr(3, 32'd1);
    @(negedge clk);
    chk("R9", "top event after restart", 32'(top_evt), 32'd1);
    c = 0;
    wr(3, 32'd0);
    c = 2;
    do begin @(negedge clk); c++; end while (!top_evt);
    chk("R9", "zero write ignored", 32'(c), 32'd80);

    // R8: master ignores ext_sync
    early = 1'b0;
    for (int j = 1; j <= 80; j++) begin
      @(negedge clk);
      if (j < 80 && top_evt) early = 1'b1;
      if (j == 80) chk("R8", "master frame end", 32'(top_evt), 32'd1);
      if (j == 10) ext_sync = 1'b1;
      if (j == 12) ext_sync = 1'b0;
    end
    chk("R8", "master early restart", 32'(early), 32'd0);

    // R8: slave restarts on rising edge only
    wr(0, 32'd1);
    wr(3, 32'd1);
    repeat (20) @(negedge clk);
    ext_sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8", "slave restart on edge", 32'(top_evt), 32'd1);
    c = 0;
    do begin @(negedge clk); c++; end while (!top_evt);
    chk("R8", "held level no retrigger", 32'(c), 32'd80);
    ext_sync = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule